// File: doc/BRIEF.md
# Dual-Mode Strobed Parallel Port

An 8-bit parallel port with two modes of use, chosen by a mode input. In static mode it is a latched output port: a write command loads a holding register whose value stays on the pins until the next write, and a read command samples the pins directly, with no input register on the pin side. In strobed mode it is a bidirectional port. A write drives the bus only around an active-low write strobe. A read lets the bus float and captures it when an active-low read strobe rises. When no transfer is running, the bus is released.

Every accepted command runs the same sequence: one setup cycle, a strobe that stays low for `STROBE_CLKS` cycles, and one hold cycle. In static mode external logic may ignore the strobes. One output-enable bit covers all lines, so the port as a whole either drives or receives. A busy output marks the sequence, and commands offered while it is high are dropped.

Top module: `strobed_bus_port`

## Requirements
- R1: After reset the port is idle: busy is 0, rdN and wrN are 1, rdValid is 0, and the output register holds 8'hFF. In static mode (strobedMode=0) pinOe is 1 and pinDataOut is 8'hFF.
- R2: In static mode, a write (cmdWrite=1) loads cmdData into the output register on the accepting edge. From the next cycle pinDataOut shows that value with pinOe=1, and it holds until the next write.
- R3: In static mode, a read (cmdWrite=0) samples pinDataIn on the accepting edge. rdData returns that value with rdValid=1 for one cycle, STROBE_CLKS+2 cycles after acceptance.
- R4: Each accepted command gives exactly one strobe pulse in either mode: wrN for writes, rdN for reads. The strobe is low for cycles 2 through STROBE_CLKS+1, counted from the accepting edge (cycle 1 is setup).
- R5: In strobed mode, a write drives cmdData with pinOe=1 from the setup cycle, one cycle before wrN falls, through the hold cycle, one cycle after wrN rises. The same write also loads the output register.
- R6: In strobed mode, a read keeps pinOe=0. It captures pinDataIn on the clock edge at which rdN rises, and reports it on rdData with rdValid=1 during the hold cycle.
- R7: In strobed mode, pinOe is 0 whenever no write sequence is running.
- R8: busy is 1 for STROBE_CLKS+2 cycles after acceptance. A cmdValid that arrives while busy is 1 has no effect on the output register, the strobes or the pins.
- R9: rdN and wrN are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobedMode | input | 1 | 1 = strobed bidirectional mode, 0 = static mode; sampled when a command is accepted |
| cmdValid | input | 1 | Command request; accepted when busy is 0 |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdData | input | DATA_W | Write data |
| busy | output | 1 | A command sequence is running |
| rdValid | output | 1 | rdData holds a completed read (one cycle) |
| rdData | output | DATA_W | Read result |
| pinDataIn | input | DATA_W | Data received from the bus pins |
| pinDataOut | output | DATA_W | Data driven onto the bus pins |
| pinOe | output | 1 | Output enable for all bus lines |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |

## Verification
Reads run while the bench changes pinDataIn on every cycle of the sequence. The value returned therefore shows which edge the port sampled: a static read must return the value present at acceptance, and a strobed read must return the value present at the rising edge of rdN. Writes with random data, issued in both modes, separate a latched output from a drive that only lasts as long as the strobe. Static checks placed after strobed writes confirm that both modes share one output register. The bench also offers a command in the middle of a busy sequence and then checks the output register, the strobes and the pins, which shows whether the port dropped it.

// File: rtl/strobed_bus_pkg.sv
package strobed_bus_pkg;
  typedef struct packed {
    logic busy;       // sequence in progress
    logic loadOut;    // load output register this edge
    logic sampleNow;  // capture pin data this edge
    logic readDone;   // read result valid from next cycle
    logic strobeLow;  // strobe phase
    logic seqWrite;   // current sequence is a write
    logic seqStrobed; // current sequence runs in strobed mode
  } bus_ctrl_t;
endpackage

// File: rtl/bus_port_ctrl.sv
module bus_port_ctrl
  import strobed_bus_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmdValid,
  input  logic      cmdWrite,
  input  logic      strobedMode,
  output bus_ctrl_t ctrl
);
  localparam int CW = $clog2(STROBE_CLKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} seq_state_e;

  seq_state_e state;
  logic [CW-1:0] cnt;
  logic seqWrite, seqStrobed;
  logic accept, endStrobe;

  assign accept    = cmdValid && (state == S_IDLE);
  assign endStrobe = (state == S_STROBE) && (cnt == CW'(STROBE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      seqWrite   <= 1'b0;
      seqStrobed <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state      <= S_SETUP;
          seqWrite   <= cmdWrite;
          seqStrobed <= strobedMode;
        end
        S_SETUP: begin
          state <= S_STROBE;
          cnt   <= '0;
        end
        S_STROBE: begin
          if (endStrobe) state <= S_HOLD;
          else           cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.busy       = (state != S_IDLE);
    ctrl.loadOut    = accept && cmdWrite;
    ctrl.sampleNow  = (accept && !cmdWrite && !strobedMode) ||
                      (endStrobe && !seqWrite && seqStrobed);
    ctrl.readDone   = endStrobe && !seqWrite;
    ctrl.strobeLow  = (state == S_STROBE);
    ctrl.seqWrite   = seqWrite;
    ctrl.seqStrobed = seqStrobed;
  end

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STROBE) |-> (cnt < CW'(STROBE_CLKS)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(seqWrite) && $stable(seqStrobed));
endmodule

// File: rtl/bus_port_datapath.sv
module bus_port_datapath
  import strobed_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ctrl_t         ctrl,
  input  logic              strobedMode,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] pinDataIn,
  output logic [DATA_W-1:0] pinDataOut,
  output logic              pinOe,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] outLatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outLatch <= '1;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (ctrl.loadOut)   outLatch <= cmdData;
      if (ctrl.sampleNow) rdData   <= pinDataIn;
      rdValid <= ctrl.readDone;
    end
  end

  assign pinDataOut = outLatch;
  assign rdN = !(ctrl.strobeLow && !ctrl.seqWrite);
  assign wrN = !(ctrl.strobeLow &&  ctrl.seqWrite);
  assign pinOe = ctrl.busy ? (ctrl.seqStrobed ? ctrl.seqWrite : 1'b1) : !strobedMode;

  // R9
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rdN && !wrN));

  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrN |-> pinOe);

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrN) |-> pinOe);

  // R6
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdN && ctrl.seqStrobed) |-> !pinOe);

  // R7
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.busy && strobedMode) |-> !pinOe);

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loadOut |=> $stable(outLatch));
endmodule

// File: rtl/strobed_bus_port.sv
module strobed_bus_port
  import strobed_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STROBE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobedMode,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] pinDataIn,
  output logic [DATA_W-1:0] pinDataOut,
  output logic              pinOe,
  output logic              rdN,
  output logic              wrN
);
  bus_ctrl_t ctrl;

  bus_port_ctrl #(.STROBE_CLKS(STROBE_CLKS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .strobedMode(strobedMode), .ctrl(ctrl)
  );

  bus_port_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .strobedMode(strobedMode),
    .cmdData(cmdData), .pinDataIn(pinDataIn), .pinDataOut(pinDataOut),
    .pinOe(pinOe), .rdN(rdN), .wrN(wrN), .rdData(rdData), .rdValid(rdValid)
  );

  assign busy = ctrl.busy;

  // R3
  rd_valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> (rdN && wrN && busy));
endmodule

// File: tb/strobed_bus_port_tb_top.sv
module strobed_bus_port_tb_top;
  localparam int DW = 8;
  localparam int S  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobedMode = 1'b0, cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [DW-1:0] cmdData = '0, pinDataIn = '0;
  logic busy, rdValid, pinOe, rdN, wrN;
  logic [DW-1:0] rdData, pinDataOut;

  int checks = 0, failures = 0;
  logic [DW-1:0] expLatch = 8'hFF;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strobed_bus_port #(.DATA_W(DW), .STROBE_CLKS(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobedMode(strobedMode), .cmdValid(cmdValid),
    .cmdWrite(cmdWrite), .cmdData(cmdData), .busy(busy), .rdValid(rdValid),
    .rdData(rdData), .pinDataIn(pinDataIn), .pinDataOut(pinDataOut),
    .pinOe(pinOe), .rdN(rdN), .wrN(wrN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expStrobe(int k);
    return (k >= 2) && (k <= S + 1);
  endfunction

  function automatic bit expDrive(bit strobed, bit wr, int k);
    if (!strobed) return 1'b1;
    return wr && (k <= S + 2);
  endfunction

  // Issue one command and follow it cycle by cycle (k = cycles since acceptance).
  task automatic runCmd(input bit wr, input bit strobed, input logic [DW-1:0] d,
                        input bit inject);
    logic [DW-1:0] expRead;
    @(negedge clk);
    strobedMode = strobed; cmdValid = 1'b1; cmdWrite = wr; cmdData = d;
    pinDataIn = DW'($urandom);
    expRead = pinDataIn;            // R3: static read samples at acceptance
    if (wr) expLatch = d;
    for (int k = 1; k <= S + 3; k++) begin
      @(negedge clk);
      chk(busy == (k <= S + 2), "R8", "busy", busy, k <= S + 2);
      chk(wrN == !(wr && expStrobe(k)), "R4", "wrN", wrN, !(wr && expStrobe(k)));
      chk(rdN == !(!wr && expStrobe(k)), "R4", "rdN", rdN, !(!wr && expStrobe(k)));
      chk(rdN || wrN, "R9", "dual strobe", {rdN, wrN}, 2'b11);
      chk(pinOe == expDrive(strobed, wr, k), strobed ? (wr ? "R5" : "R6") : "R2",
          "pinOe", pinOe, expDrive(strobed, wr, k));
      if (pinOe)
        chk(pinDataOut == expLatch, strobed ? "R5" : "R2", "pinDataOut",
            pinDataOut, expLatch);
      chk(rdValid == (!wr && k == S + 2), strobed ? "R6" : "R3", "rdValid",
          rdValid, !wr && k == S + 2);
      if (!wr && k == S + 2)
        chk(rdData == expRead, strobed ? "R6" : "R3", "rdData", rdData, expRead);
      // drive next cycle
      cmdValid = 1'b0;
      if (inject && k == 2) begin
        cmdValid = 1'b1; cmdWrite = 1'b1; cmdData = ~d;   // R8: must be dropped
      end
      pinDataIn = DW'($urandom);
      if (strobed && k == S + 1) expRead = pinDataIn;     // R6: sampled as rdN rises
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy, "R1", "busy", busy, 0);
    chk(rdN && wrN, "R1", "strobes", {rdN, wrN}, 2'b11);
    chk(!rdValid, "R1", "rdValid", rdValid, 0);
    chk(pinOe, "R1", "pinOe", pinOe, 1);
    chk(pinDataOut == 8'hFF, "R1", "pinDataOut", pinDataOut, 8'hFF);
    strobedMode = 1'b1;
    @(negedge clk);
    chk(!pinOe, "R7", "idle pinOe", pinOe, 0);

    // directed cases
    runCmd(1'b1, 1'b0, 8'h5A, 1'b0);   // R2 static write
    runCmd(1'b0, 1'b0, 8'h00, 1'b0);   // R3 static read
    chk(pinDataOut == 8'h5A, "R2", "hold after read", pinDataOut, 8'h5A);
    runCmd(1'b1, 1'b1, 8'h00, 1'b0);   // R5 strobed write
    chk(!pinOe, "R7", "float after write", pinOe, 0);
    runCmd(1'b0, 1'b1, 8'h00, 1'b0);   // R6 strobed read
    runCmd(1'b1, 1'b0, 8'hC3, 1'b1);   // R8 write with injected command
    repeat (S + 3) begin
      @(negedge clk);
      chk(rdN && wrN && !busy, "R8", "no extra sequence", {busy, rdN, wrN}, 3'b011);
    end
    runCmd(1'b0, 1'b1, 8'h00, 1'b1);   // R8 read with injected command
    strobedMode = 1'b0;
    @(negedge clk);
    chk(pinDataOut == 8'hC3, "R8", "latch kept", pinDataOut, 8'hC3);
    runCmd(1'b1, 1'b1, 8'h96, 1'b0);   // R5 strobed write loads the latch
    strobedMode = 1'b0;
    @(negedge clk);
    chk(pinDataOut == 8'h96 && pinOe, "R5", "shared latch", pinDataOut, 8'h96);

    // random mix
    for (int n = 0; n < 60; n++)
      runCmd(1'($urandom), 1'($urandom), DW'($urandom), ($urandom % 4) == 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule